// File: doc/BRIEF.md
# Bit-Oriented Message Receiver

This block monitors the serial data-link channel of an extended-superframe T1 stream, one bit per valid strobe. It searches the stream for 16-bit bit-oriented message frames, takes the 6-bit message out of each frame, and keeps a short history of recent messages. A message is accepted only after it wins a repeat vote and only when it differs from the message accepted last.

An accepted message is loaded into a 6-bit code output. Each load sets a sticky indication flag, which stays set until a clear pulse arrives. An interrupt request follows the flag, gated by an enable input. Recovery of framing and extraction of the data-link bits from the line are handled upstream.

Top module: `bom_receiver`

## Requirements
- R1: While `esf_en` is 0, no frame is recognised and `code` and `code_flag` do not change.
- R2: A frame is 16 bits, taken in arrival order as eight 1s, a 0, message bits m5 (first) to m0, then a closing 0. A word whose leading run, separator or closing bit is wrong adds nothing to the history.
- R3: With `vote_mode` = 0, a message is accepted when it matches in at least 4 of the newest 5 received frames, counting the frame just received.
- R4: With `vote_mode` = 1, a message is accepted when it matches in at least 8 of the newest 10 received frames, counting the frame just received.
- R5: A message that equals the last accepted message is not accepted again, and the flag is not set again.
- R6: On acceptance, `code` takes the message two clock cycles after the edge that samples the final frame bit. At all other times `code` holds its value.
- R7: `code_flag` is set on every acceptance and stays set until `irq_clr` is high at a clock edge. If acceptance and `irq_clr` occur on the same edge, the flag is set.
- R8: `irq` is 1 exactly when `code_flag` is 1 and `irq_en` is 1.
- R9: A bit is taken only on an edge where `dl_valid` is 1. Bits presented while the strobe is low have no effect on the frame search.
- R10: Reset clears `code` to 0, clears `code_flag`, empties the history and forgets the last accepted message. After reset the first message can be accepted only after enough frames arrive to meet the vote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dl_bit | input | 1 | Data-link bit |
| dl_valid | input | 1 | Strobe marking `dl_bit` as valid this cycle |
| esf_en | input | 1 | Extended-superframe mode; enables reception |
| vote_mode | input | 1 | 0: 4-of-5 vote, 1: 8-of-10 vote |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | One-cycle clear of the indication flag |
| code | output | 6 | Last accepted message |
| code_flag | output | 1 | Sticky indication that `code` was loaded |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an acceptance and a flag clear landing on the same clock edge. The acceptance edge sits two registers behind the last frame bit, so the bench pulses `irq_clr` at a cycle counted from the end of the frame. The vote also depends on the whole recent history. For this reason the bench keeps its own ten-entry history model and sweeps every one of the 64 message values through the 4-of-5 rule. It then slides a single outlier through each position of a 10-frame window under the 8-of-10 rule.

// File: rtl/bom_pkg.sv
package bom_pkg;
  localparam int BOM_MSG_W   = 6;
  localparam int BOM_LEAD_W  = 8;
  localparam int BOM_FRAME_W = BOM_LEAD_W + 1 + BOM_MSG_W + 1;

  typedef enum logic {VOTE_SHORT = 1'b0, VOTE_LONG = 1'b1} vote_mode_e;

  // a window of the stream holds a frame when the lead run, separator and tail line up
  function automatic logic frame_ok(input logic [BOM_FRAME_W-1:0] w);
    return (w[BOM_FRAME_W-1 -: BOM_LEAD_W] == {BOM_LEAD_W{1'b1}}) &&
           (w[BOM_MSG_W+1] == 1'b0) && (w[0] == 1'b0);
  endfunction

  function automatic logic [BOM_MSG_W-1:0] frame_msg(input logic [BOM_FRAME_W-1:0] w);
    return w[BOM_MSG_W:1];
  endfunction
endpackage

// File: rtl/bom_framer.sv
module bom_framer
  import bom_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dl_bit,
  input  logic                 dl_valid,
  input  logic                 esf_en,
  output logic                 pat_stb,
  output logic [BOM_MSG_W-1:0] pat_msg
);
  logic [BOM_FRAME_W-1:0] sr;
  logic [BOM_FRAME_W-1:0] sr_nx;
  logic                   take;
  logic                   hit;

  assign sr_nx = {sr[BOM_FRAME_W-2:0], dl_bit};
  assign take  = dl_valid & esf_en;
  assign hit   = take & frame_ok(sr_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      pat_stb <= 1'b0;
      pat_msg <= '0;
    end else begin
      pat_stb <= hit;
      if (!esf_en || hit) sr <= '0;   // the next frame needs a full set of new bits
      else if (take)      sr <= sr_nx;
      if (hit) pat_msg <= frame_msg(sr_nx);
    end
  end
endmodule

// File: rtl/bom_history.sv
module bom_history #(
  parameter  int MSG_W      = 6,
  parameter  int DEPTH      = 10,
  parameter  int SHORT_WIN  = 5,
  parameter  int SHORT_NEED = 4,
  parameter  int LONG_WIN   = 10,
  parameter  int LONG_NEED  = 8,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_stb,
  input  logic [MSG_W-1:0] pat_msg,
  input  logic             vote_mode,
  output logic             upd,
  output logic [MSG_W-1:0] newest,
  output logic [CNT_W-1:0] votes,
  output logic             quorum
);
  logic [MSG_W-1:0] hist [DEPTH];
  logic [CNT_W-1:0] fill;
  logic [CNT_W-1:0] win;
  logic [CNT_W-1:0] need;
  logic [DEPTH-1:0] agree;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      fill <= '0;
      upd  <= 1'b0;
    end else begin
      upd <= pat_stb;
      if (pat_stb) begin
        hist[0] <= pat_msg;
        for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
        if (fill != CNT_W'(DEPTH)) fill <= fill + 1'b1;
      end
    end
  end

  assign win  = (vote_mode == bom_pkg::VOTE_LONG) ? CNT_W'(LONG_WIN)  : CNT_W'(SHORT_WIN);
  assign need = (vote_mode == bom_pkg::VOTE_LONG) ? CNT_W'(LONG_NEED) : CNT_W'(SHORT_NEED);

  for (genvar g = 0; g < DEPTH; g++) begin : g_agree
    assign agree[g] = (CNT_W'(g) < fill) && (CNT_W'(g) < win) && (hist[g] == hist[0]);
  end

  always_comb begin
    votes = '0;
    for (int i = 0; i < DEPTH; i++) votes = votes + CNT_W'(agree[i]);
  end

  assign quorum = (votes >= need);
  assign newest = hist[0];
endmodule

// File: rtl/bom_declare.sv
module bom_declare #(
  parameter int MSG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [MSG_W-1:0] newest,
  input  logic             quorum,
  input  logic             esf_en,
  input  logic             irq_clr,
  output logic             decl,
  output logic [MSG_W-1:0] code,
  output logic             flag,
  output logic             had_decl
);
  // the code register doubles as the record of the last accepted message
  assign decl = upd & quorum & esf_en & (~had_decl | (newest != code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code     <= '0;
      flag     <= 1'b0;
      had_decl <= 1'b0;
    end else begin
      if (decl) begin
        code     <= newest;
        had_decl <= 1'b1;
      end
      if (decl)         flag <= 1'b1;
      else if (irq_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/bom_receiver.sv
module bom_receiver
  import bom_pkg::*;
#(
  parameter int DEPTH      = 10,
  parameter int SHORT_WIN  = 5,
  parameter int SHORT_NEED = 4,
  parameter int LONG_WIN   = 10,
  parameter int LONG_NEED  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dl_bit,
  input  logic                 dl_valid,
  input  logic                 esf_en,
  input  logic                 vote_mode,
  input  logic                 irq_en,
  input  logic                 irq_clr,
  output logic [BOM_MSG_W-1:0] code,
  output logic                 code_flag,
  output logic                 irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                 pat_stb;
  logic [BOM_MSG_W-1:0] pat_msg;
  logic                 upd;
  logic [BOM_MSG_W-1:0] newest;
  logic [CNT_W-1:0]     votes;
  logic                 quorum;
  logic                 decl;
  logic                 had_decl;

  bom_framer u_framer (
    .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .dl_valid(dl_valid),
    .esf_en(esf_en), .pat_stb(pat_stb), .pat_msg(pat_msg)
  );

  bom_history #(
    .MSG_W(BOM_MSG_W), .DEPTH(DEPTH), .SHORT_WIN(SHORT_WIN), .SHORT_NEED(SHORT_NEED),
    .LONG_WIN(LONG_WIN), .LONG_NEED(LONG_NEED)
  ) u_history (
    .clk(clk), .rst_n(rst_n), .pat_stb(pat_stb), .pat_msg(pat_msg),
    .vote_mode(vote_mode), .upd(upd), .newest(newest), .votes(votes), .quorum(quorum)
  );

  bom_declare #(.MSG_W(BOM_MSG_W)) u_declare (
    .clk(clk), .rst_n(rst_n), .upd(upd), .newest(newest), .quorum(quorum),
    .esf_en(esf_en), .irq_clr(irq_clr), .decl(decl), .code(code),
    .flag(code_flag), .had_decl(had_decl)
  );

  assign irq = code_flag & irq_en;
endmodule

// File: rtl/bom_receiver_chk.sv
module bom_receiver_chk #(
  parameter int MSG_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dl_valid,
  input logic             esf_en,
  input logic             irq_clr,
  input logic             pat_stb,
  input logic             decl,
  input logic             had_decl,
  input logic [MSG_W-1:0] code,
  input logic             code_flag
);
  AST_ESF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(esf_en) |-> !pat_stb);                                          // R1
  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dl_valid) |-> !pat_stb);                                        // R9
  AST_NEW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (decl && had_decl) |=> (code != $past(code)));                         // R5
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !decl |=> $stable(code));                                              // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    decl |=> code_flag);                                                   // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !decl) |=> !code_flag);                                    // R7
endmodule

bind bom_receiver bom_receiver_chk #(.MSG_W(bom_pkg::BOM_MSG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dl_valid(dl_valid), .esf_en(esf_en), .irq_clr(irq_clr),
  .pat_stb(pat_stb), .decl(decl), .had_decl(had_decl), .code(code), .code_flag(code_flag)
);

// File: tb/bom_receiver_test.sv
`timescale 1ns/1ps
module bom_receiver_test;
  logic clk = 1'b0, rst_n = 1'b0, dl_bit = 1'b0, dl_valid = 1'b0;
  logic esf_en = 1'b0, vote_mode = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  wire [5:0] code;
  wire       code_flag, irq;

  int n_chk = 0, n_err = 0;
  int mh[10];
  int mcnt = 0;
  bit mlv = 0, mflag = 0;
  int mcode = 0;

  always #2 clk = ~clk;

  bom_receiver uut (
    .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .dl_valid(dl_valid), .esf_en(esf_en),
    .vote_mode(vote_mode), .irq_en(irq_en), .irq_clr(irq_clr),
    .code(code), .code_flag(code_flag), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    chk(req, "code", 32'(code), 32'(mcode));
    chk(req, "flag", 32'(code_flag), 32'(mflag));
    chk(req, "irq", 32'(irq), 32'(mflag && irq_en));
  endtask

  task automatic model_reset();
    mcnt = 0; mlv = 0; mcode = 0; mflag = 0;
  endtask

  // returns 1 when the message is accepted
  function automatic bit model_push(input int m);
    int win, need, votes;
    for (int i = 9; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = m;
    if (mcnt < 10) mcnt++;
    win  = vote_mode ? 10 : 5;
    need = vote_mode ? 8 : 4;
    votes = 0;
    for (int i = 0; i < win && i < mcnt; i++) if (mh[i] == m) votes++;
    if (votes >= need && (!mlv || m != mcode)) begin
      mcode = m; mlv = 1; mflag = 1;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  // sends a 16-bit word first bit first; junk_at inserts strobe-low cycles before that bit
  task automatic send_word(input logic [15:0] w, input int junk_at, input bit clr);
    for (int i = 15; i >= 0; i--) begin
      if (i == junk_at) begin
        for (int j = 0; j < 3; j++) begin
          @(negedge clk); dl_valid = 1'b0; dl_bit = j[0];
        end
      end
      @(negedge clk); dl_bit = w[i]; dl_valid = 1'b1;
    end
    @(negedge clk); dl_valid = 1'b0;
    @(negedge clk); irq_clr = clr;    // lands on the acceptance edge
    @(negedge clk); irq_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame(input int m, input int junk_at = -1, input bit clr = 0);
    bit d;
    send_word({8'hff, 1'b0, 6'(m), 1'b0}, junk_at, clr);
    d = esf_en ? model_push(m) : 1'b0;
    if (clr && !d) mflag = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    mflag = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out("R10 reset");
    rst_n = 1'b1;

    // R1: no reception outside ESF mode
    for (int r = 0; r < 5; r++) frame(5);
    check_out("R1");

    esf_en = 1'b1; vote_mode = 1'b0; irq_en = 1'b1;

    // R3 R6: every message value under the 4-of-5 rule
    for (int m = 0; m < 64; m++) begin
      for (int r = 0; r < 4; r++) begin
        frame(m);
        check_out("R3/R6");
        if (mflag) pulse_clr();
      end
    end

    // R5: repeating the accepted message raises nothing
    for (int r = 0; r < 5; r++) begin frame(63); check_out("R5"); end

    // R3: alternating messages never reach 4 of 5
    for (int r = 0; r < 6; r++) begin frame(r[0] ? 20 : 10); check_out("R3 alt"); end
    // R3: one outlier in the middle still passes
    frame(30); frame(30); frame(7); frame(30); check_out("R3 outlier");
    frame(30); check_out("R3 outlier accept");
    pulse_clr();

    // R4: outlier walked through every slot of a 10-frame window
    vote_mode = 1'b1;
    for (int k = 0; k < 10; k++) begin
      for (int p = 0; p < 10; p++) begin
        frame(p == k ? 62 : 40 + k);
        check_out("R4");
      end
      if (mflag) pulse_clr();
    end

    // R2: malformed words enter no history
    vote_mode = 1'b0;
    for (int r = 0; r < 3; r++) frame(50);
    send_word({8'hff, 1'b0, 6'd50, 1'b1}, -1, 0); check_out("R2 bad tail");
    send_word({8'hff, 1'b1, 6'd50, 1'b0}, -1, 0); check_out("R2 bad separator");
    send_word({8'h7f, 1'b0, 6'd50, 1'b0}, -1, 0); check_out("R2 short lead");
    frame(50); check_out("R2 good after bad");
    pulse_clr();

    // R9: strobe-low cycles inside frames are skipped
    for (int r = 0; r < 4; r++) begin frame(33, 7 - r); check_out("R9"); end

    // R7: sticky flag, set beats clear on the same edge
    for (int r = 0; r < 3; r++) frame(12);
    frame(12, -1, 1); check_out("R7 set wins");
    frame(5); check_out("R7 sticky");
    pulse_clr(); check_out("R7 cleared");
    for (int r = 0; r < 4; r++) frame(5);
    check_out("R7 set again");

    // R8: enable gates the request
    irq_en = 1'b0; #1; check_out("R8 masked");
    irq_en = 1'b1; #1; check_out("R8 unmasked");

    // R10: reset mid-run forgets history and the last message
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); model_reset(); check_out("R10 mid reset");
    rst_n = 1'b1;
    for (int r = 0; r < 3; r++) begin frame(5); check_out("R10 refill"); end
    frame(5); check_out("R10 first accept");

    finish_run();
  end
endmodule